// File: doc/BRIEF.md
# Serial Memory-Access Engine with Single/Quad Lane Switching

This block is the host side of a serial link to a display controller whose registers and memory sit in a 22-bit address space. A client presents one request at a time on a request/acknowledge port: read or write 1, 2 or 4 bytes at an address, send a three-byte host command, or reprogram the engine's own lane mode. The engine frames each transaction with an active-low chip select, generates the serial clock from a programmable divider, shifts the address header and data out, and for reads gathers the returned bytes into a little-endian word.

After reset the engine runs in single-line SPI mode 0 (one output lane, one input lane, 8-bit framing, most significant bit first). Software first writes the device's own width register with an ordinary write. It then issues a separate mode request to the engine. From then on, memory accesses use four lanes, a nibble per clock with the high nibble first. In quad reads the lanes are released once the header has gone out. A mode bit adds a second dummy byte to every read, for fast clock rates. Host commands always go out on a single lane.

Top module: `qspi_mem_engine`

## Requirements
- R1: A request is taken while `req` is high and the engine is idle. Completion is a single-cycle `ack` pulse, issued only after chip select has returned high. For reads, `rdata` holds the result while `ack` is high.
- R2: A write (`req_op`=1) sends a 24-bit header whose bits 23:22 are binary 10 and whose bits 21:0 are `req_addr`, followed by the data bytes.
- R3: A read (`req_op`=0) sends a header with bits 23:22 equal to binary 00, then one dummy byte, then clocks in the data bytes.
- R4: `req_size` 0, 1, 2 selects 1, 2, 4 bytes and 3 also selects 4. Data on the wire is little-endian (bits 7:0 first), and `rdata` is zero above the bytes read.
- R5: A host command (`req_op`=2) sends exactly three bytes, `req_cmd`, `req_param`, 0x00, with no prefix, always on one lane whatever the engine mode.
- R6: `sclk` idles low and rises only inside a frame. Output lanes change only while `sclk` is low and inputs are sampled on its rising edge. Bits go most significant first.
- R7: Chip select stays low for the whole frame (header, dummy and data) and falls exactly once per transaction. When chip select is high, `io_oe` is 0000.
- R8: `req_op`=3 loads the engine mode from `req_wdata[2:0]` without any bus activity. Bits 1:0 equal to binary 10 select quad lanes, and any other value selects a single lane. Reset gives single lane with no extra dummy.
- R9: In quad mode each byte takes two `sclk` cycles, high nibble first, with `io_out[3:0]` carrying nibble bits 3:0 and `io_oe`=1111 while driving.
- R10: In a quad read, `io_oe` is 0000 from the end of the 24-bit header to the end of the frame.
- R11: When mode bit 2 is set, every read carries two dummy bytes instead of one, in either lane mode.
- R12: `sclk` is high and low for h system clocks each, where h = `clk_div` (0 counts as 1). Chip select stays high for at least 2h clocks between frames.
- R13: In single-lane mode `io_oe` is 0001 during the frame. `io_out[0]` is the output lane and `io_in[1]` is the input lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until ack |
| req_op | input | 2 | 0 read, 1 write, 2 host command, 3 set engine mode |
| req_addr | input | 22 | Memory address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, or mode value in bits 2:0 |
| req_cmd | input | 8 | Host command byte |
| req_param | input | 8 | Host command parameter |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read result |
| clk_div | input | DIV_W | Half-period of sclk in system clocks |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The bench models the device: it records every rising `sclk` edge and serves read data lane by lane. Each frame is decoded against a header, dummy and data stream computed independently. Directed frames include a 16-bit write of 800 to 0x302034, whose wire image is fixed, and a size code of 3, so byte order and size decoding are caught. Random mixes of reads, writes and host commands run across all engine mode values and several divider settings. They separate single-lane from quad framing, single from double dummy bytes, and the lane release in quad reads from the always-driven lanes of host commands. Between frames the bench checks the pulse widths and chip-select gaps, and confirms that mode requests leave the bus untouched.

// File: rtl/qspi_mem_engine.sv
module qspi_mem_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [1:0]       req_op,
  input  logic [21:0]      req_addr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic [7:0]       req_cmd,
  input  logic [7:0]       req_param,
  output logic             ack,
  output logic [31:0]      rdata,
  input  logic [DIV_W-1:0] clk_div,
  output logic             sclk,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  localparam int FRAME_W = 72;
  localparam int CNT_W   = 7;
  localparam int TIM_W   = DIV_W + 1;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_CMD = 2'd2, OP_MODE = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_GAP} state_t;

  state_t             st;
  logic [2:0]         mode;
  logic               quad_q, rd_q;
  logic [2:0]         nby_q;
  logic [DIV_W-1:0]   h_q;
  logic [FRAME_W-1:0] tx;
  logic [31:0]        rx;
  logic [CNT_W-1:0]   cnt, nbits, dstart;
  logic [TIM_W-1:0]   tim;

  wire [DIV_W-1:0] half   = (clk_div == '0) ? DIV_W'(1) : clk_div;
  wire [2:0]       nby    = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  wire [2:0]       ndum   = mode[2] ? 3'd2 : 3'd1;
  wire [23:0]      hdr    = {(req_op == OP_WR) ? 2'b10 : 2'b00, req_addr};
  wire [31:0]      wle    = {req_wdata[7:0], req_wdata[15:8], req_wdata[23:16], req_wdata[31:24]};
  wire [CNT_W-1:0] d_init = CNT_W'(24) + CNT_W'({ndum, 3'b000});

  logic [FRAME_W-1:0] tx_init;
  logic [CNT_W-1:0]   nbits_init;
  always_comb begin
    case (req_op)
      OP_CMD: begin
        tx_init    = {req_cmd, req_param, 8'h00, 48'h0};
        nbits_init = CNT_W'(24);
      end
      OP_WR: begin
        tx_init    = {hdr, wle, 16'h0};
        nbits_init = CNT_W'(24) + CNT_W'({nby, 3'b000});
      end
      default: begin
        tx_init    = {hdr, 48'h0};
        nbits_init = d_init + CNT_W'({nby, 3'b000});
      end
    endcase
  end

  wire [TIM_W-1:0] h_last   = TIM_W'(h_q) - TIM_W'(1);
  wire [TIM_W-1:0] gap_last = {h_q, 1'b0} - TIM_W'(1);
  wire [CNT_W-1:0] cnt_nxt  = cnt + (quad_q ? CNT_W'(4) : CNT_W'(1));

  logic [31:0] rx_le;
  always_comb begin
    case (nby_q)
      3'd1:    rx_le = {24'h0, rx[7:0]};
      3'd2:    rx_le = {16'h0, rx[7:0], rx[15:8]};
      default: rx_le = {rx[7:0], rx[15:8], rx[23:16], rx[31:24]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  mode <= '0;   quad_q <= 1'b0; rd_q <= 1'b0;
      nby_q <= '0;   h_q <= DIV_W'(1); tx <= '0;   rx <= '0;
      cnt <= '0;     nbits <= '0;  dstart <= '0;   tim <= '0;
      sclk <= 1'b0;  cs_n <= 1'b1; ack <= 1'b0;    rdata <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: if (req && !ack) begin
          if (req_op == OP_MODE) begin
            mode <= req_wdata[2:0];
            ack  <= 1'b1;
          end else begin
            tx     <= tx_init;
            nbits  <= nbits_init;
            dstart <= d_init;
            quad_q <= (req_op != OP_CMD) && (mode[1:0] == 2'b10);
            rd_q   <= (req_op == OP_RD);
            nby_q  <= nby;
            h_q    <= half;
            cnt    <= '0;
            tim    <= '0;
            rx     <= '0;
            cs_n   <= 1'b0;
            st     <= S_LOW;
          end
        end
        S_LOW: if (tim == h_last) begin
          tim  <= '0;
          sclk <= 1'b1;
          st   <= S_HIGH;
          if (rd_q && cnt >= dstart)
            rx <= quad_q ? {rx[27:0], io_in} : {rx[30:0], io_in[1]};
        end else tim <= tim + TIM_W'(1);
        S_HIGH: if (tim == h_last) begin
          tim  <= '0;
          sclk <= 1'b0;
          cnt  <= cnt_nxt;
          tx   <= quad_q ? (tx << 4) : (tx << 1);
          if (cnt_nxt >= nbits) begin
            cs_n <= 1'b1;
            st   <= S_GAP;
          end else st <= S_LOW;
        end else tim <= tim + TIM_W'(1);
        S_GAP: if (tim == gap_last) begin
          tim   <= '0;
          ack   <= 1'b1;
          rdata <= rx_le;
          st    <= S_IDLE;
        end else tim <= tim + TIM_W'(1);
        default: st <= S_IDLE;
      endcase
    end
  end

  assign io_out = cs_n ? 4'h0 : (quad_q ? tx[FRAME_W-1 -: 4] : {3'b000, tx[FRAME_W-1]});
  assign io_oe  = cs_n ? 4'h0 :
                  (!quad_q ? 4'h1 : ((rd_q && cnt >= CNT_W'(24)) ? 4'h0 : 4'hF));

  logic [2:0] gapc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gapc <= 3'd7;
    else if (!cs_n)      gapc <= 3'd0;
    else if (gapc != 3'd7) gapc <= gapc + 3'd1;
  end

  AST_SCLK_IDLE_LOW:   assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);                // R6
  AST_SCLK_IN_FRAME:   assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> !cs_n);        // R6
  AST_LANES_RELEASED:  assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> io_oe == 4'h0);       // R7
  AST_ACK_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n) ack |-> cs_n);                 // R1
  AST_ACK_PULSE:       assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);                 // R1
  AST_FRAME_BOUND:     assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> cnt < nbits);        // R7
  AST_CS_GAP:          assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> gapc >= 3'd2); // R12
  AST_LANE_CHANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                                        (sclk && $past(sclk) && !cs_n) |-> $stable(io_out));              // R6
endmodule

// File: tb/qspi_mem_engine_tb.sv
module qspi_mem_engine_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, req, ack, sclk, cs_n;
  logic [1:0]  req_op, req_size;
  logic [21:0] req_addr;
  logic [31:0] req_wdata, rdata;
  logic [7:0]  req_cmd, req_param, clk_div;
  logic [3:0]  io_out, io_oe, io_in;

  qspi_mem_engine #(.DIV_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_op(req_op), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_cmd(req_cmd), .req_param(req_param),
    .ack(ack), .rdata(rdata), .clk_div(clk_div), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  int checks = 0, fails = 0;
  logic [2:0]  m_mode = 3'd0;
  logic [3:0]  rec_out [0:79];
  logic [3:0]  rec_oe  [0:79];
  int          rises = 0, lo_run = 0, hi_run = 0, run_bad = 0, gap_run = 0, last_gap = 0, cs_falls = 0;
  int          exp_h = 1;
  logic        prev_sclk = 1'b0, prev_cs = 1'b1, squad = 1'b0;
  logic [71:0] sstream = '0, last_cap = '0;

  task automatic chk(input bit ok, input string r, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [71:0] exp_stream(input logic [1:0] op, input logic [21:0] a, input logic [1:0] sz,
                                             input logic [31:0] wd, input logic [7:0] c, input logic [7:0] p);
    logic [71:0] s;
    s = '0;
    if (op == 2'd2) s[71:48] = {c, p, 8'h00};
    else begin
      s[71:48] = {(op == 2'd1) ? 2'b10 : 2'b00, a};
      if (op == 2'd1)
        for (int j = 0; j < nbytes(sz); j++) s = s | (72'(wd[8*j +: 8]) << (40 - 8*j));
    end
    return s;
  endfunction

  // bus model: records rising edges, checks pulse widths, serves read data
  always @(negedge clk) begin
    logic [71:0] t;
    if (prev_cs && !cs_n) begin cs_falls++; last_gap = gap_run; rises = 0; lo_run = 0; hi_run = 0; end
    if (!prev_sclk && sclk) begin
      if (lo_run != exp_h) run_bad++;
      if (rises < 80) begin rec_out[rises] = io_out; rec_oe[rises] = io_oe; end
      rises++; lo_run = 0;
    end
    if (prev_sclk && !sclk) begin
      if (hi_run != exp_h) run_bad++;
      hi_run = 0;
    end
    if (!cs_n) begin if (sclk) hi_run++; else lo_run++; end
    gap_run = cs_n ? gap_run + 1 : 0;
    if (cs_n || rises >= 72) io_in = 4'h0;
    else if (squad) begin t = sstream << (4*rises); io_in = t[71:68]; end
    else begin t = sstream << rises; io_in = {2'b00, t[71], 1'b0}; end
    prev_sclk = sclk; prev_cs = cs_n;
  end

  task automatic set_mode(input logic [2:0] v);
    int f0;
    f0 = cs_falls;
    @(negedge clk);
    req = 1'b1; req_op = 2'd3; req_wdata = {29'h0, v};
    while (!ack) @(negedge clk);
    req = 1'b0;
    m_mode = v;
    @(negedge clk);
    chk(cs_falls == f0, "R8", "mode request bus activity", cs_falls - f0, 0);
  endtask

  task automatic run(input logic [1:0] op, input logic [21:0] a, input logic [1:0] sz, input logic [31:0] wd,
                     input logic [7:0] c, input logic [7:0] p, input logic [31:0] rv, input logic [7:0] dv);
    int n, ndum, nbits, w, erises, drv, bad_oe, f0, h;
    bit q, rd;
    logic [71:0] e, cap, mask;
    logic [31:0] erd, got;
    n = nbytes(sz); ndum = m_mode[2] ? 2 : 1; rd = (op == 2'd0);
    q = (op != 2'd2) && (m_mode[1:0] == 2'b10);
    w = q ? 4 : 1;
    nbits = (op == 2'd2) ? 24 : rd ? 24 + 8*ndum + 8*n : 24 + 8*n;
    erises = nbits / w;
    e = exp_stream(op, a, sz, wd, c, p);
    h = (dv == 0) ? 1 : int'(dv);
    sstream = '0;
    if (rd) for (int j = 0; j < n; j++) sstream = sstream | (72'(rv[8*j +: 8]) << (64 - 24 - 8*ndum - 8*j));
    erd = (n == 4) ? rv : (n == 2) ? {16'h0, rv[15:0]} : {24'h0, rv[7:0]};
    @(negedge clk);
    clk_div = dv; exp_h = h; squad = q; run_bad = 0; f0 = cs_falls;
    req = 1'b1; req_op = op; req_addr = a; req_size = sz; req_wdata = wd; req_cmd = c; req_param = p;
    while (!ack) @(negedge clk);
    got = rdata;
    req = 1'b0;
    @(negedge clk);
    chk(ack == 1'b0, "R1", "ack width", ack, 0);
    chk(cs_falls == f0 + 1, "R7", "chip select falls per frame", cs_falls - f0, 1);
    chk(rises == erises, q ? "R9" : "R6", "sclk rising edges", rises, erises);
    cap = '0; bad_oe = 0;
    for (int k = 0; k < rises && k < 72; k++) begin
      if (q) cap = cap | (72'(rec_out[k]) << (68 - 4*k));
      else   cap = cap | (72'(rec_out[k][0]) << (71 - k));
      if (q) begin if (rec_oe[k] != ((rd && k >= 6) ? 4'h0 : 4'hF)) bad_oe++; end
      else if (rec_oe[k] != 4'h1) bad_oe++;
    end
    last_cap = cap;
    drv = rd ? 24 : nbits;
    mask = ~72'h0 << (72 - drv);
    chk((cap & mask) == (e & mask), (op == 2'd2) ? "R5" : rd ? "R3" : "R2", "wire stream", cap & mask, e & mask);
    chk(bad_oe == 0, q ? "R10" : "R13", "lane enables", bad_oe, 0);
    chk(run_bad == 0, "R12", "sclk half-period length", run_bad, 0);
    if (rd) chk(got == erd, m_mode[2] ? "R11" : "R4", "read data", got, erd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    rst_n = 1'b0; req = 1'b0; req_op = '0; req_addr = '0; req_size = '0; req_wdata = '0;
    req_cmd = '0; req_param = '0; clk_div = 8'd1; io_in = '0;
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0, "R6", "reset bus idle", {cs_n, sclk}, 2'b10);
    chk(io_oe == 4'h0 && ack == 1'b0, "R7", "reset lanes released", {io_oe, ack}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run(2'd1, 22'h302034, 2'd1, 32'd800, 8'h0, 8'h0, 32'h0, 8'd2);
    chk(last_cap[71:32] == 40'hB020342003, "R4", "16-bit 800 write image", last_cap[71:32], 40'hB020342003);
    run(2'd0, 22'h302000, 2'd0, 32'h0, 8'h0, 8'h0, 32'h0000007C, 8'd1);
    run(2'd2, 22'h0, 2'd0, 32'h0, 8'h44, 8'h00, 32'h0, 8'd3);
    run(2'd1, 22'h3FFFFF, 2'd3, 32'hDEADBEEF, 8'h0, 8'h0, 32'h0, 8'd0);   // R4 size code 3
    chk(last_cap[71:16] == 56'hBFFFFFEFBEADDE, "R4", "size 3 write image", last_cap[71:16], 56'hBFFFFFEFBEADDE);
    run(2'd1, 22'h302188, 2'd0, 32'h2, 8'h0, 8'h0, 32'h0, 8'd1);
    set_mode(3'd2);
    run(2'd0, 22'h302188, 2'd0, 32'h0, 8'h0, 8'h0, 32'h00000002, 8'd1);   // R10 quad read
    run(2'd1, 22'h302034, 2'd1, 32'd800, 8'h0, 8'h0, 32'h0, 8'd2);        // R9 quad write
    chk(last_cap[71:32] == 40'hB020342003, "R9", "quad nibble order", last_cap[71:32], 40'hB020342003);
    run(2'd2, 22'h0, 2'd0, 32'h0, 8'h61, 8'h46, 32'h0, 8'd1);             // R5 single in quad mode
    set_mode(3'd6);
    run(2'd0, 22'h30200C, 2'd2, 32'h0, 8'h0, 8'h0, 32'h044AA200, 8'd2);   // R11
    set_mode(3'd4);
    run(2'd0, 22'h000123, 2'd1, 32'h0, 8'h0, 8'h0, 32'h0000A55A, 8'd5);   // R11 single lane
    set_mode(3'd0);

    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 7) == 0) set_mode(3'($urandom_range(0, 7)));
      run(2'($urandom_range(0, 2)), 22'($urandom), 2'($urandom_range(0, 3)), $urandom,
          8'($urandom), 8'($urandom), $urandom, 8'($urandom_range(0, 3)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule